// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block lets clocked on-chip logic use an external asynchronous static RAM of 512K bytes. A client presents one request at a time (address, write byte and a write/read flag) under a valid/ready handshake. The controller turns each request into a sequence of active-low strobes (chip select, output enable, write strobe), a held address and a data bus that the controller drives only through its own output-enable. Read bytes come back with a one-cycle valid pulse.

Every analogue timing rule of the memory is a parameter in nanoseconds: power-up wait, read access, write strobe width, data setup to write end, address setup to write end, and bus release time. Each becomes a clock-cycle count equal to the ceiling of the nanoseconds over the clock period, never less than one. After reset the controller waits out the power-up delay before it accepts anything. A write always starts with a release phase so that the memory's output drivers are off before the controller drives data. Every access ends with one recovery cycle.

Top module: `asram_ctrl`

## Requirements
- R1: While reset is asserted and directly after it, req_ready is 0, mem_ce_n, mem_oe_n and mem_we_n are 1 and mem_dq_oe is 0.
- R2: req_ready first goes high exactly PWR_CYC = max(1, ceil(PWRUP_NS/CLK_NS)) clock edges after reset is released (100 by default). Before then the strobes stay inactive, even with req_valid held high.
- R3: A request is taken only on an edge where req_valid and req_ready are both 1. req_ready then stays low until the access has finished: ACC_CYC+1 cycles for a read and TURN_CYC+WE_CYC+1 cycles for a write (3 and 3 by default).
- R4: A read holds mem_ce_n=0, mem_oe_n=0 and mem_we_n=1 for ACC_CYC = max(1, ceil(ACCESS_NS/CLK_NS)) cycles. It samples mem_dq_in at the end of the last of those cycles and presents the byte on rsp_rdata with a one-cycle rsp_valid pulse, ACC_CYC+1 cycles after acceptance.
- R5: A write holds mem_we_n=0 for exactly WE_CYC cycles, where WE_CYC is max(1, ceil of the largest of WE_PULSE_NS, DATA_SETUP_NS and ADDR_TO_END_NS over CLK_NS). The write ends with mem_we_n rising while mem_ce_n is still 0.
- R6: Before each write strobe, mem_ce_n is 0 with mem_oe_n=1, mem_we_n=1 and mem_dq_oe=0 for TURN_CYC = max(1, ceil(TURN_NS/CLK_NS)) cycles. This gives the memory time to release the bus.
- R7: mem_dq_oe is 1 only while mem_we_n=0, mem_oe_n=1 and mem_ce_n=0. It is never 1 while the memory could still be driving the bus.
- R8: Every access ends with one recovery cycle (mem_ce_n=0, mem_oe_n=1, mem_we_n=1). Whenever req_ready is 1, all three strobes are 1.
- R9: mem_addr stays stable for as long as mem_ce_n stays low. A byte written to an address reads back unchanged until it is overwritten.
- R10: Written data is driven on mem_dq_out for the whole strobe, so data setup and address setup to the write end each equal at least WE_CYC clock periods.

asram_ctrl port list:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Client request present |
| req_ready | output | 1 | Controller can take a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Byte address of the request |
| req_wdata | input | 8 | Byte to write |
| rsp_rdata | output | 8 | Byte returned by the last read |
| rsp_valid | output | 1 | One-cycle pulse, rsp_rdata is new |
| mem_ce_n | output | 1 | Memory chip select, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_addr | output | 19 | Memory address bus |
| mem_dq_out | output | 8 | Data the controller places on the bus |
| mem_dq_oe | output | 1 | Tristate enable for mem_dq_out |
| mem_dq_in | input | 8 | Data seen on the bus |

## Verification
The assertions assume that clk really has the period given by CLK_NS, since every cycle count is derived from that number. They also assume that the memory's data is settled on mem_dq_in by the sampling edge whenever the access parameter covers its access time. The bench's memory model keeps to this. It returns a wrong byte until ACCESS_NS has passed since the address or output enable last changed, it keeps driving for TURN_NS after output enable rises, and it times strobe width, data setup and address setup against the same nanosecond limits. The client stimulus holds req_valid until acceptance and runs a 100 MHz clock, which matches the default CLK_NS.

// File: rtl/asram_pkg.sv
`timescale 1ns/1ps
package asram_pkg;

    typedef enum logic [2:0] {
        ST_INIT,
        ST_IDLE,
        ST_READ,
        ST_WSETUP,
        ST_WPULSE,
        ST_RECOVER
    } seq_state_e;

    typedef struct packed {
        seq_state_e state;
        logic       ce_n;
        logic       oe_n;
        logic       we_n;
        logic       dq_oe;
    } seq_regs_t;

    // ceiling of ns / period, never below one cycle
    function automatic int unsigned ns_to_cycles(input int unsigned ns,
                                                 input int unsigned period_ns);
        int unsigned c;
        c = (ns + period_ns - 1) / period_ns;
        return (c == 0) ? 1 : c;
    endfunction

    function automatic int unsigned max3(input int unsigned a,
                                         input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/asram_wait_cnt.sv
`timescale 1ns/1ps
module asram_wait_cnt #(
    parameter int unsigned CNT_W   = 8,
    parameter int unsigned RST_VAL = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             done_o
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = load_val_i;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= CNT_W'(RST_VAL);
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign done_o = (cnt_q == '0);

endmodule

// File: rtl/asram_seq.sv
`timescale 1ns/1ps
module asram_seq
    import asram_pkg::*;
#(
    parameter int unsigned CNT_W    = 8,
    parameter int unsigned TURN_CYC = 1,
    parameter int unsigned ACC_CYC  = 2,
    parameter int unsigned WE_CYC   = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid_i,
    input  logic             req_write_i,
    input  logic             cnt_done_i,
    output logic             ready_o,
    output logic             accept_o,
    output logic             capture_o,
    output logic             cnt_load_o,
    output logic [CNT_W-1:0] cnt_val_o,
    output logic             ce_n_o,
    output logic             oe_n_o,
    output logic             we_n_o,
    output logic             dq_oe_o
);

    localparam logic [CNT_W-1:0] TURN_LD = CNT_W'(TURN_CYC - 1);
    localparam logic [CNT_W-1:0] ACC_LD  = CNT_W'(ACC_CYC - 1);
    localparam logic [CNT_W-1:0] WE_LD   = CNT_W'(WE_CYC - 1);

    seq_regs_t seq_d, seq_q;

    always_comb begin
        seq_d      = seq_q;
        cnt_load_o = 1'b0;
        cnt_val_o  = '0;
        case (seq_q.state)
            ST_INIT: begin
                if (cnt_done_i) seq_d.state = ST_IDLE;
            end
            ST_IDLE: begin
                if (req_valid_i) begin
                    cnt_load_o = 1'b1;
                    if (req_write_i) begin
                        seq_d.state = ST_WSETUP;
                        cnt_val_o   = TURN_LD;
                    end else begin
                        seq_d.state = ST_READ;
                        cnt_val_o   = ACC_LD;
                    end
                end
            end
            ST_READ: begin
                if (cnt_done_i) seq_d.state = ST_RECOVER;
            end
            ST_WSETUP: begin
                if (cnt_done_i) begin
                    seq_d.state = ST_WPULSE;
                    cnt_load_o  = 1'b1;
                    cnt_val_o   = WE_LD;
                end
            end
            ST_WPULSE: begin
                if (cnt_done_i) seq_d.state = ST_RECOVER;
            end
            ST_RECOVER: seq_d.state = ST_IDLE;
            default:    seq_d.state = ST_IDLE;
        endcase
        // strobes are decoded from the next state so they leave a flop
        seq_d.ce_n  = (seq_d.state == ST_INIT) || (seq_d.state == ST_IDLE);
        seq_d.oe_n  = (seq_d.state != ST_READ);
        seq_d.we_n  = (seq_d.state != ST_WPULSE);
        seq_d.dq_oe = (seq_d.state == ST_WPULSE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{state: ST_INIT, ce_n: 1'b1, oe_n: 1'b1,
                       we_n: 1'b1, dq_oe: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign ready_o   = (seq_q.state == ST_IDLE);
    assign accept_o  = ready_o && req_valid_i;
    assign capture_o = (seq_q.state == ST_READ) && cnt_done_i;
    assign ce_n_o    = seq_q.ce_n;
    assign oe_n_o    = seq_q.oe_n;
    assign we_n_o    = seq_q.we_n;
    assign dq_oe_o   = seq_q.dq_oe;

endmodule

// File: rtl/asram_dpath.sv
`timescale 1ns/1ps
module asram_dpath #(
    parameter int unsigned ADDR_W = 19,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept_i,
    input  logic              capture_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [DATA_W-1:0] req_wdata_i,
    input  logic [DATA_W-1:0] mem_dq_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] wdata_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              rsp_valid_o
);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
        logic              rsp_valid;
    } dp_regs_t;

    dp_regs_t dp_d, dp_q;

    always_comb begin
        dp_d           = dp_q;
        dp_d.rsp_valid = capture_i;
        if (accept_i) begin
            dp_d.addr  = req_addr_i;
            dp_d.wdata = req_wdata_i;
        end
        if (capture_i) begin
            dp_d.rdata = mem_dq_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dp_q <= '0;
        end else begin
            dp_q <= dp_d;
        end
    end

    assign addr_o      = dp_q.addr;
    assign wdata_o     = dp_q.wdata;
    assign rdata_o     = dp_q.rdata;
    assign rsp_valid_o = dp_q.rsp_valid;

endmodule

// File: rtl/asram_ctrl.sv
`timescale 1ns/1ps
module asram_ctrl
    import asram_pkg::*;
#(
    parameter int unsigned ADDR_W         = 19,
    parameter int unsigned DATA_W         = 8,
    parameter int unsigned CLK_NS         = 10,
    parameter int unsigned PWRUP_NS       = 1000,
    parameter int unsigned ACCESS_NS      = 12,
    parameter int unsigned WE_PULSE_NS    = 10,
    parameter int unsigned DATA_SETUP_NS  = 7,
    parameter int unsigned ADDR_TO_END_NS = 10,
    parameter int unsigned TURN_NS        = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_valid,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);

    localparam int unsigned PWR_CYC  = ns_to_cycles(PWRUP_NS, CLK_NS);
    localparam int unsigned ACC_CYC  = ns_to_cycles(ACCESS_NS, CLK_NS);
    localparam int unsigned WE_CYC   = ns_to_cycles(
        max3(WE_PULSE_NS, DATA_SETUP_NS, ADDR_TO_END_NS), CLK_NS);
    localparam int unsigned TURN_CYC = ns_to_cycles(TURN_NS, CLK_NS);
    localparam int unsigned MAX_CYC  = max3(max3(PWR_CYC, ACC_CYC, 1),
                                            WE_CYC, TURN_CYC);
    localparam int unsigned CNT_W    = $clog2(MAX_CYC) + 1;

    logic             cnt_load;
    logic [CNT_W-1:0] cnt_val;
    logic             cnt_done;
    logic             accept;
    logic             capture;

    asram_wait_cnt #(
        .CNT_W   (CNT_W),
        .RST_VAL (PWR_CYC - 1)
    ) wait_cnt_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (cnt_load),
        .load_val_i (cnt_val),
        .done_o     (cnt_done)
    );

    asram_seq #(
        .CNT_W    (CNT_W),
        .TURN_CYC (TURN_CYC),
        .ACC_CYC  (ACC_CYC),
        .WE_CYC   (WE_CYC)
    ) seq_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid_i (req_valid),
        .req_write_i (req_write),
        .cnt_done_i  (cnt_done),
        .ready_o     (req_ready),
        .accept_o    (accept),
        .capture_o   (capture),
        .cnt_load_o  (cnt_load),
        .cnt_val_o   (cnt_val),
        .ce_n_o      (mem_ce_n),
        .oe_n_o      (mem_oe_n),
        .we_n_o      (mem_we_n),
        .dq_oe_o     (mem_dq_oe)
    );

    asram_dpath #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) dpath_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .accept_i    (accept),
        .capture_i   (capture),
        .req_addr_i  (req_addr),
        .req_wdata_i (req_wdata),
        .mem_dq_i    (mem_dq_in),
        .addr_o      (mem_addr),
        .wdata_o     (mem_dq_out),
        .rdata_o     (rsp_rdata),
        .rsp_valid_o (rsp_valid)
    );

endmodule

// File: rtl/asram_ctrl_chk.sv
`timescale 1ns/1ps
module asram_ctrl_chk #(
    parameter int unsigned ADDR_W  = 19,
    parameter int unsigned WE_CYC  = 1,
    parameter int unsigned PWR_CYC = 100
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic              mem_ce_n,
    input logic              mem_oe_n,
    input logic              mem_we_n,
    input logic              mem_dq_oe,
    input logic [ADDR_W-1:0] mem_addr
);

    logic [15:0] we_low_run;
    logic [15:0] since_rst;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            we_low_run <= '0;
            since_rst  <= '0;
        end else begin
            if (!mem_we_n) begin
                if (we_low_run != 16'hFFFF) we_low_run <= we_low_run + 1'b1;
            end else begin
                we_low_run <= '0;
            end
            if (since_rst < 16'(PWR_CYC)) since_rst <= since_rst + 1'b1;
        end
    end

    a_r2_no_ready_before_powerup: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst < 16'(PWR_CYC)) |-> !req_ready);

    a_r8_idle_strobes_off: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_ce_n && mem_oe_n && mem_we_n));

    a_r4_read_strobes: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> (!mem_ce_n && mem_we_n));

    a_r5_we_width: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (we_low_run == 16'(WE_CYC)));

    a_r5_we_rises_selected: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> !mem_ce_n);

    a_r7_drive_only_in_write: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> (!mem_we_n && mem_oe_n && !mem_ce_n));

    a_r6_no_drive_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |=> !mem_dq_oe);

    a_r4_rsp_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    a_r9_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

endmodule

bind asram_ctrl asram_ctrl_chk #(
    .ADDR_W  (ADDR_W),
    .WE_CYC  (WE_CYC),
    .PWR_CYC (PWR_CYC)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .mem_ce_n  (mem_ce_n),
    .mem_oe_n  (mem_oe_n),
    .mem_we_n  (mem_we_n),
    .mem_dq_oe (mem_dq_oe),
    .mem_addr  (mem_addr)
);

// File: tb/asram_ctrl_tb_top.sv
`timescale 1ns/1ps
module asram_ctrl_tb_top;

    localparam int AW = 19;
    localparam int DW = 8;
    localparam int CLK_NS = 10;
    localparam int T_PWR = 1000, T_ACC = 12, T_PWE = 10, T_SD = 7, T_AW = 10, T_TURN = 6;

    function automatic int cyc(input int ns);
        int c;
        c = (ns + CLK_NS - 1) / CLK_NS;
        return (c < 1) ? 1 : c;
    endfunction

    localparam int PWR_E  = (T_PWR + CLK_NS - 1) / CLK_NS;
    localparam int ACC_E  = (T_ACC + CLK_NS - 1) / CLK_NS;
    localparam int WE_E   = (T_PWE + CLK_NS - 1) / CLK_NS;
    localparam int TURN_E = (T_TURN + CLK_NS - 1) / CLK_NS;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic req_ready, rsp_valid;
    logic [DW-1:0] rsp_rdata;
    logic mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_dq_out;
    logic [DW-1:0] mem_dq_in = 8'h5A;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_NS/2) clk = ~clk;

    asram_ctrl dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_rdata(rsp_rdata), .rsp_valid(rsp_valid),
        .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
        .mem_dq_in(mem_dq_in)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // ---------------- behavioural memory model ----------------
    logic [DW-1:0] model_mem [int];
    realtime rd_start = 0.0, rd_end = -1000.0;
    realtime we_fall = 0.0, addr_chg = 0.0, data_chg = 0.0;
    bit rd_act = 1'b0, we_seen = 1'b0;

    always @(mem_ce_n or mem_oe_n or mem_we_n or mem_addr) begin
        bit c;
        c = (mem_ce_n === 1'b0) && (mem_oe_n === 1'b0) && (mem_we_n === 1'b1);
        if (c) rd_start = $realtime;
        else if (rd_act) rd_end = $realtime;
        rd_act = c;
    end

    always @(mem_addr) addr_chg = $realtime;
    always @(mem_dq_out) data_chg = $realtime;

    always @(negedge mem_we_n) begin
        if (mem_ce_n === 1'b0) begin
            we_fall = $realtime;
            we_seen = 1'b1;
        end
    end

    always @(posedge mem_we_n) begin
        if (we_seen) begin
            we_seen = 1'b0;
            chk(mem_ce_n === 1'b0, "R5", "chip select low at write end", mem_ce_n, 0);
            chk(($realtime - we_fall) >= T_PWE, "R5", "write strobe width ns",
                longint'($realtime - we_fall), T_PWE);
            chk(($realtime - data_chg) >= T_SD, "R10", "data setup ns",
                longint'($realtime - data_chg), T_SD);
            chk(($realtime - addr_chg) >= T_AW, "R10", "address setup ns",
                longint'($realtime - addr_chg), T_AW);
            model_mem[int'(mem_addr)] = mem_dq_out;
        end
    end

    // read data becomes valid only after the access time
    initial begin
        #0.5;
        forever begin
            if (rd_act && ($realtime - rd_start) >= T_ACC)
                mem_dq_in = model_mem.exists(int'(mem_addr)) ? model_mem[int'(mem_addr)] : 8'h3C;
            else
                mem_dq_in = 8'h5A;
            #1;
        end
    end

    // bus contention monitor
    always @(negedge clk) begin
        if (rst_n && mem_dq_oe === 1'b1) begin
            chk(!rd_act && (($realtime - rd_end) >= T_TURN), "R7",
                "controller drives while memory may drive (ns since release)",
                longint'($realtime - rd_end), T_TURN);
        end
    end

    // ---------------- stimulus helpers ----------------
    function automatic logic [AW-1:0] addr_of(input int i);
        if (i < AW) return AW'(1) << i;
        if (i == AW) return '0;
        if (i == AW + 1) return '1;
        return AW'(32'h40000 + (i - AW - 2) * 3);
    endfunction

    function automatic logic [DW-1:0] pat(input logic [AW-1:0] a, input int salt);
        return a[7:0] ^ a[15:8] ^ {a[18:16], 5'b0} ^ DW'(salt * 8'h5B + 8'h11);
    endfunction

    task automatic access(input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                          output int busy, output int rsp_at, output logic [DW-1:0] rdat);
        int n;
        n = 0;
        rsp_at = -1;
        rdat = '0;
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_addr = a;
        req_wdata = d;
        @(posedge clk);
        do begin
            @(negedge clk);
            n++;
            if (n == 1) begin
                req_valid = 1'b0;
                req_addr = ~a;
                req_wdata = ~d;
            end
            if (rsp_valid) begin
                rsp_at = n;
                rdat = rsp_rdata;
            end
        end while (!req_ready && n < 1000);
        busy = n - 1;
    endtask

    task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        int busy, ra;
        logic [DW-1:0] rd;
        access(1'b1, a, d, busy, ra, rd);
        chk(busy == TURN_E + WE_E + 1, "R3", "write busy cycles", busy, TURN_E + WE_E + 1);
        chk(ra == -1, "R4", "no response pulse on write", ra, -1);
    endtask

    task automatic do_read(input logic [AW-1:0] a, input logic [DW-1:0] exp);
        int busy, ra;
        logic [DW-1:0] rd;
        access(1'b0, a, '0, busy, ra, rd);
        chk(busy == ACC_E + 1, "R3", "read busy cycles", busy, ACC_E + 1);
        chk(ra == ACC_E + 1, "R4", "read response cycle", ra, ACC_E + 1);
        chk(rd == exp, "R9", "read data", rd, exp);
    endtask

    task automatic report;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        #(150_000 * CLK_NS);
        if (!done) begin
            chk(1'b0, "WDOG", "watchdog expired", 0, 1);
            report();
        end
    end

    // ---------------- main sequence ----------------
    initial begin
        int n;
        bit quiet;
        // R1: reset state
        @(negedge clk);
        chk(req_ready === 1'b0, "R1", "ready in reset", req_ready, 0);
        chk({mem_ce_n, mem_oe_n, mem_we_n} === 3'b111, "R1", "strobes in reset",
            {mem_ce_n, mem_oe_n, mem_we_n}, 7);
        chk(mem_dq_oe === 1'b0, "R1", "bus enable in reset", mem_dq_oe, 0);
        @(negedge clk);
        rst_n = 1'b1;
        // R2: power-up wait with a request pending
        req_valid = 1'b1;
        req_write = 1'b1;
        n = 0;
        quiet = 1'b1;
        while (!req_ready && n < 10_000) begin
            @(negedge clk);
            n++;
            if (!(mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe)) quiet = 1'b0;
            if (n >= PWR_E - 1) req_valid = 1'b0;
        end
        chk(n == PWR_E, "R2", "cycles until ready", n, PWR_E);
        chk(quiet, "R2", "strobes quiet during power-up", quiet, 1);
        chk(cyc(T_ACC) == ACC_E && cyc(3) == 1, "R10", "cycle rounding", cyc(3), 1);
        @(negedge clk);
        chk(mem_ce_n && mem_oe_n && mem_we_n, "R8", "idle strobes after power-up",
            {mem_ce_n, mem_oe_n, mem_we_n}, 7);

        // R9 sweep: write everything, then read everything
        for (int i = 0; i < AW + 2 + 64; i++) do_write(addr_of(i), pat(addr_of(i), 0));
        for (int i = 0; i < AW + 2 + 64; i++) do_read(addr_of(i), pat(addr_of(i), 0));

        // R6/R9: overwrite, read back, read a neighbour, then write right after a read
        for (int i = 0; i < 16; i++) begin
            do_write(addr_of(i), pat(addr_of(i), 1));
            do_read(addr_of(i), pat(addr_of(i), 1));
            do_read(addr_of(AW + 2 + i), pat(addr_of(AW + 2 + i), 0));
            do_write(addr_of(AW + 2 + i), pat(addr_of(AW + 2 + i), 2));
        end
        for (int i = 0; i < 16; i++)
            do_read(addr_of(AW + 2 + i), pat(addr_of(AW + 2 + i), 2));

        // R8: strobes idle once back in idle
        @(negedge clk);
        chk(req_ready && mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe, "R8",
            "idle state after traffic", {mem_ce_n, mem_oe_n, mem_we_n}, 7);
        done = 1'b1;
        report();
    end

endmodule